// File: doc/BRIEF.md
# Serial Test Chain with One-Bit Bypass

This block is a serial test-access path for the pins of a synchronous memory. It runs on its own scan clock and has four test signals: the scan clock, a level-sensitive scan enable, a serial input and a serial output. With scan enable high, a chain of cells, one per captured pin, moves data from the serial input toward the serial output by one cell on every rising scan clock edge. With scan enable low, a single bypass bit takes the place of the chain. This gives a test controller a one-cycle path through the device.

Both paths capture on the rising edge of the scan clock and launch on the falling edge, so the next device in a board-level chain always samples a serial output that has been stable for half a cycle. The chain length is a parameter. There is no state machine and no instruction register: the scan enable level alone picks the path. The scan cells do not drive the memory pins.

Top module: `scan_bypass_chain`

## Requirements
- R1: An active-low asynchronous reset clears every chain cell and the bypass bit and drives the serial output low at once.
- R2: While scan enable is high at a rising scan clock edge, the serial input enters cell 0 and every cell i takes the value of cell i-1. Cell CHAIN_LEN-1 is the cell nearest the output.
- R3: When scan enable was high at the latest rising edge, the serial output takes the value of cell CHAIN_LEN-1 on the next falling edge.
- R4: A bit pattern shifted in with scan enable held high leaves the serial output unchanged and in the same order. The first bit appears after the falling edge that follows the CHAIN_LEN-th rising edge.
- R5: While scan enable is low at a rising edge, the serial input is sampled into the bypass bit. It appears on the serial output at the following falling edge, one clock after it was sampled.
- R6: While scan enable is low, the chain cells keep their contents. When scan enable goes high again, shifting resumes and the held bits come out in their original order.
- R7: The serial output source chosen at each falling edge is fixed by the scan enable level at the rising edge before it: the chain tail when high, the bypass bit when low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| scanClk | input | 1 | Scan clock; capture on rising edge, launch on falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| scanEn | input | 1 | 1 selects the chain, 0 selects the bypass bit |
| scanIn | input | 1 | Serial data input |
| scanOut | output | 1 | Serial data output |

## Verification
The bench shifts a mixed pattern through a four-cell chain and checks that the first bit comes out on the fourth shift and not one cycle early or late. An off-by-one in the cell indexing or launch edge would skew the whole stream. It then switches to bypass in the middle of the stream with a bypass bit that differs from the chain tail. A design that kept sourcing the chain would show the wrong bit, and a design that shifted the chain during bypass would lose the held bits when chain mode resumes. A reset applied with ones in every cell must force the output low at once and make the next shifts produce zeros, which a design that leaves cells uncleared would fail.

// File: rtl/scan_pkg.sv
package scan_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;     // advance chain at this rising edge
    logic bypassCap;   // load bypass bit at this rising edge
    logic outSelChain; // falling-edge launch takes chain tail
  } scan_strobe_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
(
  input  logic         scanClk,
  input  logic         rstN,
  input  logic         scanEn,
  output scan_strobe_t strobe
);
  logic modeReg;

  // Mode seen at the rising edge steers the following launch
  always_ff @(posedge scanClk or negedge rstN) begin
    if (!rstN) modeReg <= 1'b0;
    else       modeReg <= scanEn;
  end

  always_comb begin
    strobe.shiftEn     = scanEn;
    strobe.bypassCap   = !scanEn;
    strobe.outSelChain = modeReg;
  end
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int CHAIN_LEN = 13
) (
  input  logic                 scanClk,
  input  logic                 rstN,
  input  logic                 scanIn,
  input  scan_strobe_t         strobe,
  output logic [CHAIN_LEN-1:0] chainVec,
  output logic                 bypassBit,
  output logic                 scanOut
);
  localparam int TAIL = CHAIN_LEN - 1;

  logic [CHAIN_LEN-1:0] cellD;

  generate
    for (genvar i = 0; i < CHAIN_LEN; i++) begin : gCell
      if (i == 0) begin : gHead
        assign cellD[i] = scanIn;
      end else begin : gBody
        assign cellD[i] = chainVec[i-1];
      end
      always_ff @(posedge scanClk or negedge rstN) begin
        if (!rstN)               chainVec[i] <= 1'b0;
        else if (strobe.shiftEn) chainVec[i] <= cellD[i];
      end
    end
  endgenerate

  always_ff @(posedge scanClk or negedge rstN) begin
    if (!rstN)                 bypassBit <= 1'b0;
    else if (strobe.bypassCap) bypassBit <= scanIn;
  end

  // Launch on the falling edge
  always_ff @(negedge scanClk or negedge rstN) begin
    if (!rstN) scanOut <= 1'b0;
    else       scanOut <= strobe.outSelChain ? chainVec[TAIL] : bypassBit;
  end
endmodule

// File: rtl/scan_bypass_chain.sv
module scan_bypass_chain
  import scan_pkg::*;
#(
  parameter int CHAIN_LEN = 13
) (
  input  logic scanClk,
  input  logic rstN,
  input  logic scanEn,
  input  logic scanIn,
  output logic scanOut
);
  scan_strobe_t         strobe;
  logic [CHAIN_LEN-1:0] chainVec;
  logic                 bypassBit;

  scan_ctrl u_ctrl (
    .scanClk(scanClk),
    .rstN   (rstN),
    .scanEn (scanEn),
    .strobe (strobe)
  );

  scan_datapath #(.CHAIN_LEN(CHAIN_LEN)) u_dp (
    .scanClk  (scanClk),
    .rstN     (rstN),
    .scanIn   (scanIn),
    .strobe   (strobe),
    .chainVec (chainVec),
    .bypassBit(bypassBit),
    .scanOut  (scanOut)
  );
endmodule

// File: rtl/scan_bypass_chain_chk.sv
module scan_bypass_chain_chk #(
  parameter int CHAIN_LEN = 13
) (
  input logic                 scanClk,
  input logic                 rstN,
  input logic                 scanEn,
  input logic                 scanIn,
  input logic                 scanOut,
  input logic [CHAIN_LEN-1:0] chainVec,
  input logic                 bypassBit
);
  localparam int TAIL = CHAIN_LEN - 1;

  AST_RESET_OUT_LOW: assert property (@(posedge scanClk)
    !rstN |-> scanOut == 1'b0); // R1

  AST_HEAD_TAKES_INPUT: assert property (@(posedge scanClk) disable iff (!rstN)
    scanEn |=> chainVec[0] == $past(scanIn)); // R2

  AST_CELLS_ADVANCE: assert property (@(posedge scanClk) disable iff (!rstN)
    scanEn |=> chainVec[TAIL:1] == $past(chainVec[TAIL-1:0])); // R2

  AST_CHAIN_LAUNCH: assert property (@(posedge scanClk) disable iff (!rstN)
    scanEn |=> scanOut == chainVec[TAIL]); // R3

  AST_BYPASS_ONE_CLOCK: assert property (@(posedge scanClk) disable iff (!rstN)
    !scanEn |=> scanOut == $past(scanIn)); // R5

  AST_BYPASS_LOADED: assert property (@(posedge scanClk) disable iff (!rstN)
    !scanEn |=> bypassBit == $past(scanIn)); // R5

  AST_CHAIN_HOLDS: assert property (@(posedge scanClk) disable iff (!rstN)
    !scanEn |=> $stable(chainVec)); // R6
endmodule

bind scan_bypass_chain scan_bypass_chain_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
  .scanClk  (scanClk),
  .rstN     (rstN),
  .scanEn   (scanEn),
  .scanIn   (scanIn),
  .scanOut  (scanOut),
  .chainVec (chainVec),
  .bypassBit(bypassBit)
);

// File: tb/scan_bypass_chain_test.sv
module scan_bypass_chain_test;
  localparam int N = 4;
  localparam int NVEC = 16;
  // Each entry: {scanIn, scanEn, expected scanOut after the falling edge}
  localparam logic [2:0] VEC [NVEC] = '{
    3'b110, 3'b010, 3'b110, 3'b111,  // shift 1,0,1,1; first bit out on 4th (R4)
    3'b010, 3'b011, 3'b111,          // stream continues in order (R3)
    3'b101, 3'b000, 3'b101, 3'b000,  // bypass, one-clock latency (R5, R7)
    3'b010, 3'b010, 3'b011, 3'b010,  // held bits resume 0,0,1 then new 0 (R6)
    3'b101                           // back to bypass (R7)
  };

  logic scanClk = 1'b0;
  logic rstN, scanEn, scanIn;
  logic scanOut;
  int   errors = 0;
  int   checks = 0;
  bit   done = 0;

  always #10 scanClk = ~scanClk;

  scan_bypass_chain #(.CHAIN_LEN(N)) uut (
    .scanClk(scanClk),
    .rstN   (rstN),
    .scanEn (scanEn),
    .scanIn (scanIn),
    .scanOut(scanOut)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (scanOut !== exp) begin
      errors++;
      $display("FAIL %s: scanOut=%b expected=%b at %0t", req, scanOut, exp, $time);
    end
  endtask

  task automatic tick(input logic din, input logic en);
    scanIn = din;
    scanEn = en;
    @(posedge scanClk);
    @(negedge scanClk);
    #2;
  endtask

  initial begin
    rstN = 1'b0; scanEn = 1'b0; scanIn = 1'b0;
    #25;
    check("R1 reset state", 1'b0);
    @(negedge scanClk); #2;
    rstN = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      tick(VEC[k][2], VEC[k][1]);
      check($sformatf("R4/R5/R6/R7 vector %0d", k), VEC[k][0]);
    end

    // all ones through the chain: zeros leave first, then ones (R2, R4)
    for (int k = 0; k < 2 * N - 1; k++) begin
      tick(1'b1, 1'b1);
      if (k >= N - 1) check("R2 ones arrive", 1'b1);
    end

    // mid-stream reset forces output low at once (R1)
    rstN = 1'b0;
    #1;
    check("R1 async clear", 1'b0);
    @(negedge scanClk); #2;
    rstN = 1'b1;
    for (int k = 0; k < N; k++) begin
      tick(1'b0, 1'b1);
      check("R1 cells cleared", 1'b0);
    end
    tick(1'b1, 1'b1);
    check("R3 tail zero after clear", 1'b0);
    tick(1'b1, 1'b0);
    check("R5 bypass after reset", 1'b1);
    tick(1'b0, 1'b0);
    check("R5 bypass zero", 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: expired expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule